// File: doc/BRIEF.md
# Decoder Status Word with Sticky Event Flags

This block holds the 32-bit status word that a host pulls from a paging decoder over a serial packet link. The word combines three kinds of content. The upper byte is a fixed packet code. It also carries the frame and cycle position last seen at the end of block 0. The rest is a set of mode bits and clear-on-read event flags. The decoder core feeds the block single-cycle strobes for power control, synchronisation, frame timing, battery sampling, minute ticks, end-of-frame and buffer overflow. The host's read strobe clears the sticky flags.

The block also raises a host-attention line whenever an enabled event is pending. The host polls the word when attention is raised. The word is presented while the read strobe is high, and the flags clear at that clock edge. An event that arrives in the same cycle as the read stays pending for the next read.

Top module: `dsw_status_word`

## Requirements
- R1: After reset `status_o` is 0x7F00_0000 and `attn_o` is 0. Bits [31:24] always read 0x7F, and the unused bits [13:12], 5, 3 and 1 read 0.
- R2: While powered on, an end-of-block-0 strobe loads the frame number into bits [22:16] and the cycle number into bits [11:8]. Frame-info-valid (bit 23) becomes 1 on that strobe when the frame-info strobe is also high and sync mode (bit 15) is 1.
- R3: Frame-info-valid goes to 0 on a sync-lost event, on an async-entry event and on turn-off. It is never 1 while sync mode is 0.
- R4: Sync mode (bit 15) becomes 1 on a sync-found event and 0 on a sync-lost event. Turn-off forces it to 0.
- R5: After turn-on, the first sync-found or search-window-expired event sets sync-update (bit 7), even when sync mode stays 0.
- R6: After that first result, sync-update is set only by a change of sync mode through sync-found or sync-lost. Later window expiries and turn-off never set it.
- R7: A battery sample strobe while on copies the pin into low-battery (bit 14). It sets low-battery-update (bit 6) when the pin differs from the held value. The first sample after turn-on compares against the value loaded at turn-on.
- R8: Turn-on loads low-battery with the inverse of the polarity input and leaves low-battery-update unchanged.
- R9: A minute tick sets bit 4, an end-of-frame event sets bit 2 and a buffer-overflow event sets bit 0.
- R10: The read strobe clears bits 7, 6, 4, 2 and 0. A flag whose set event arrives in the same cycle as the read stays 1.
- R11: `attn_o` is 1 when any of these holds: bit 7 with the sync enable, bit 4 with the minute enable, bit 6, bit 2 or bit 0.
- R12: While powered off, sync, frame and battery-sample strobes change no bit of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_i | input | 1 | Turn-on strobe |
| pwr_off_i | input | 1 | Turn-off strobe (wins over turn-on) |
| lb_pol_i | input | 1 | Low-battery polarity configuration |
| sync_en_i | input | 1 | Attention enable for sync-update |
| minute_en_i | input | 1 | Attention enable for minute timeout |
| blk0_end_i | input | 1 | End of block 0 strobe |
| frame_num_i | input | 7 | Frame number sampled at end of block 0 |
| cycle_num_i | input | 4 | Cycle number sampled at end of block 0 |
| finfo_ok_i | input | 1 | Valid frame info word seen in this frame |
| sync_found_i | input | 1 | Sync words found |
| sync_lost_i | input | 1 | Sync declared lost |
| search_exp_i | input | 1 | Sync search window expired |
| async_i | input | 1 | Asynchronous mode entered |
| minute_i | input | 1 | One-minute tick |
| lb_sample_i | input | 1 | Battery pin sample strobe |
| lb_pin_i | input | 1 | Battery pin level |
| eof_i | input | 1 | End-of-frame event |
| ovf_i | input | 1 | Buffer overflow event |
| read_i | input | 1 | Host read of the status word |
| status_o | output | 32 | Status word |
| attn_o | output | 1 | Host attention request |

## Verification
The assertions check several relations on every cycle. Turn-off always drops sync mode and frame-info-valid without raising sync-update. A rise of sync mode always leaves sync-update set. A differing battery sample always raises its update flag. A read never leaves a flag set unless its event coincided with the read. Frame-info-valid never stands without sync mode. Other behaviour needs an ordered history, so only the bench scenarios can show it. The bench checks that the first search expiry after turn-on counts and later ones do not, and that strobes are ignored while off. It also checks the turn-on battery load, the first-sample comparison against that load, and the attention line under each enable combination.

// File: rtl/dsw_pkg.sv
`timescale 1ns/1ps
package dsw_pkg;
  localparam int FRAME_W = 7;
  localparam int CYCLE_W = 4;
  localparam int ID_W    = 8;
  localparam int WORD_W  = 32;
  localparam int N_EVT   = 3;  // minute, end-of-frame, overflow
  localparam int EVT_MIN = 0;
  localparam int EVT_EOF = 1;
  localparam int EVT_OVF = 2;

  typedef struct packed {
    logic [ID_W-1:0]    id;
    logic               fiv;
    logic [FRAME_W-1:0] frame;
    logic               sm;
    logic               lb;
    logic [1:0]         rsv_hi;
    logic [CYCLE_W-1:0] cycle;
    logic               smu;
    logic               lbu;
    logic               rsv_b5;
    logic               mt;
    logic               rsv_b3;
    logic               eof;
    logic               rsv_b1;
    logic               boe;
  } status_t;
endpackage

// File: rtl/dsw_sync_track.sv
`timescale 1ns/1ps
module dsw_sync_track (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic on_i,
  input  logic off_i,
  input  logic found_i,
  input  logic lost_i,
  input  logic expired_i,
  input  logic read_i,
  output logic sm_o,
  output logic smu_o
);
  logic sm_q, smu_q, first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sm_q    <= 1'b0;
      smu_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (read_i) smu_q <= 1'b0;
      if (off_i) begin
        sm_q    <= 1'b0;
        first_q <= 1'b0;
      end else if (on_i) begin
        first_q <= 1'b1;
      end else if (active_i) begin
        if (found_i && !sm_q) begin
          sm_q  <= 1'b1;
          smu_q <= 1'b1;
        end else if (lost_i && sm_q) begin
          sm_q  <= 1'b0;
          smu_q <= 1'b1;
        end
        if (first_q && (found_i || expired_i)) begin
          smu_q   <= 1'b1;
          first_q <= 1'b0;
        end
      end
    end
  end

  assign sm_o  = sm_q;
  assign smu_o = smu_q;

  AST_OFF_DROPS_SM:  assert property (@(posedge clk) disable iff (rst) off_i |=> !sm_q);                 // R4
  AST_OFF_NO_SMU:    assert property (@(posedge clk) disable iff (rst) (off_i && !smu_q) |=> !smu_q);    // R6
  AST_SM_RISE_FLAGS: assert property (@(posedge clk) disable iff (rst) $rose(sm_q) |-> smu_q);          // R6
endmodule

// File: rtl/dsw_lowbat.sv
`timescale 1ns/1ps
module dsw_lowbat (
  input  logic clk,
  input  logic rst,
  input  logic active_i,
  input  logic on_i,
  input  logic pol_i,
  input  logic sample_i,
  input  logic pin_i,
  input  logic read_i,
  output logic lb_o,
  output logic lbu_o
);
  logic lb_q, lbu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_q  <= 1'b0;
      lbu_q <= 1'b0;
    end else begin
      if (read_i) lbu_q <= 1'b0;
      if (on_i) begin
        lb_q <= ~pol_i;
      end else if (active_i && sample_i) begin
        lb_q <= pin_i;
        if (pin_i != lb_q) lbu_q <= 1'b1;
      end
    end
  end

  assign lb_o  = lb_q;
  assign lbu_o = lbu_q;

  AST_LB_CHANGE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (active_i && !on_i && sample_i && (pin_i != lb_q)) |=> lbu_q);                                    // R7
  AST_ON_NO_LBU:  assert property (@(posedge clk) disable iff (rst) (on_i && !lbu_q) |=> !lbu_q);      // R8
  AST_ON_LOADS_LB: assert property (@(posedge clk) disable iff (rst) on_i |=> (lb_q == !$past(pol_i))); // R8
endmodule

// File: rtl/dsw_frame_info.sv
`timescale 1ns/1ps
module dsw_frame_info #(
  parameter int FRAME_W = 7,
  parameter int CYCLE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               active_i,
  input  logic               off_i,
  input  logic               sm_i,
  input  logic               blk0_i,
  input  logic               finfo_i,
  input  logic               lost_i,
  input  logic               async_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CYCLE_W-1:0] cycle_i,
  output logic               fiv_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CYCLE_W-1:0] cycle_o
);
  logic               fiv_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CYCLE_W-1:0] cycle_q;
  logic               drop;

  assign drop = off_i || (active_i && (lost_i || async_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      fiv_q   <= 1'b0;
      frame_q <= '0;
      cycle_q <= '0;
    end else begin
      if (active_i && blk0_i && !off_i) begin
        frame_q <= frame_i;
        cycle_q <= cycle_i;
        if (finfo_i && sm_i) fiv_q <= 1'b1;
      end
      if (drop) fiv_q <= 1'b0;
    end
  end

  assign fiv_o   = fiv_q;
  assign frame_o = frame_q;
  assign cycle_o = cycle_q;

  AST_OFF_DROPS_FIV: assert property (@(posedge clk) disable iff (rst) off_i |=> !fiv_q); // R3
endmodule

// File: rtl/dsw_sticky.sv
`timescale 1ns/1ps
module dsw_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         read_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (read_i)   q[i] <= 1'b0;
    end
    AST_SET_SURVIVES: assert property (@(posedge clk) disable iff (rst) set_i[i] |=> q[i]);             // R10
    AST_READ_CLEARS:  assert property (@(posedge clk) disable iff (rst) (read_i && !set_i[i]) |=> !q[i]); // R10
  end

  assign q_o = q;
endmodule

// File: rtl/dsw_status_word.sv
`timescale 1ns/1ps
module dsw_status_word
  import dsw_pkg::*;
#(
  parameter logic [ID_W-1:0] PKT_ID = 8'h7F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwr_on_i,
  input  logic               pwr_off_i,
  input  logic               lb_pol_i,
  input  logic               sync_en_i,
  input  logic               minute_en_i,
  input  logic               blk0_end_i,
  input  logic [FRAME_W-1:0] frame_num_i,
  input  logic [CYCLE_W-1:0] cycle_num_i,
  input  logic               finfo_ok_i,
  input  logic               sync_found_i,
  input  logic               sync_lost_i,
  input  logic               search_exp_i,
  input  logic               async_i,
  input  logic               minute_i,
  input  logic               lb_sample_i,
  input  logic               lb_pin_i,
  input  logic               eof_i,
  input  logic               ovf_i,
  input  logic               read_i,
  output logic [WORD_W-1:0]  status_o,
  output logic               attn_o
);
  logic               active_q;
  logic               on_evt, off_evt;
  logic               sm, smu, lb, lbu, fiv;
  logic [FRAME_W-1:0] frame;
  logic [CYCLE_W-1:0] cycle;
  logic [N_EVT-1:0]   evt_set, evt_q;
  status_t            word;

  assign off_evt = pwr_off_i;
  assign on_evt  = pwr_on_i && !pwr_off_i && !active_q;

  always_ff @(posedge clk) begin
    if (rst)          active_q <= 1'b0;
    else if (off_evt) active_q <= 1'b0;
    else if (on_evt)  active_q <= 1'b1;
  end

  dsw_sync_track u_sync (
    .clk(clk), .rst(rst), .active_i(active_q), .on_i(on_evt), .off_i(off_evt),
    .found_i(sync_found_i), .lost_i(sync_lost_i), .expired_i(search_exp_i),
    .read_i(read_i), .sm_o(sm), .smu_o(smu)
  );

  dsw_lowbat u_lowbat (
    .clk(clk), .rst(rst), .active_i(active_q), .on_i(on_evt), .pol_i(lb_pol_i),
    .sample_i(lb_sample_i), .pin_i(lb_pin_i), .read_i(read_i),
    .lb_o(lb), .lbu_o(lbu)
  );

  dsw_frame_info #(.FRAME_W(FRAME_W), .CYCLE_W(CYCLE_W)) u_frame (
    .clk(clk), .rst(rst), .active_i(active_q), .off_i(off_evt), .sm_i(sm),
    .blk0_i(blk0_end_i), .finfo_i(finfo_ok_i), .lost_i(sync_lost_i),
    .async_i(async_i), .frame_i(frame_num_i), .cycle_i(cycle_num_i),
    .fiv_o(fiv), .frame_o(frame), .cycle_o(cycle)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EVT_MIN] = minute_i;
    evt_set[EVT_EOF] = eof_i;
    evt_set[EVT_OVF] = ovf_i;
  end

  dsw_sticky #(.N(N_EVT)) u_evt (
    .clk(clk), .rst(rst), .set_i(evt_set), .read_i(read_i), .q_o(evt_q)
  );

  always_comb begin
    word        = '0;
    word.id     = PKT_ID;
    word.fiv    = fiv;
    word.frame  = frame;
    word.sm     = sm;
    word.lb     = lb;
    word.cycle  = cycle;
    word.smu    = smu;
    word.lbu    = lbu;
    word.mt     = evt_q[EVT_MIN];
    word.eof    = evt_q[EVT_EOF];
    word.boe    = evt_q[EVT_OVF];
  end

  assign status_o = word;
  assign attn_o   = (smu && sync_en_i) || (evt_q[EVT_MIN] && minute_en_i)
                  || lbu || evt_q[EVT_EOF] || evt_q[EVT_OVF];

  AST_FIV_NEEDS_SM: assert property (@(posedge clk) disable iff (rst) fiv |-> sm);                      // R3
  AST_OFF_FREEZES_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !pwr_on_i && !sm) |=> !sm);                                                             // R12
endmodule

// File: tb/tb_dsw_status_word.sv
`timescale 1ns/1ps
module tb_dsw_status_word;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_on_i = 0, pwr_off_i = 0, lb_pol_i = 0, sync_en_i = 0, minute_en_i = 0;
  logic blk0_end_i = 0, finfo_ok_i = 0, sync_found_i = 0, sync_lost_i = 0;
  logic search_exp_i = 0, async_i = 0, minute_i = 0, lb_sample_i = 0, lb_pin_i = 0;
  logic eof_i = 0, ovf_i = 0, read_i = 0;
  logic [6:0]  frame_num_i = '0;
  logic [3:0]  cycle_num_i = '0;
  logic [31:0] status_o;
  logic        attn_o;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dsw_status_word dut (
    .clk(clk), .rst(rst), .pwr_on_i(pwr_on_i), .pwr_off_i(pwr_off_i), .lb_pol_i(lb_pol_i),
    .sync_en_i(sync_en_i), .minute_en_i(minute_en_i), .blk0_end_i(blk0_end_i),
    .frame_num_i(frame_num_i), .cycle_num_i(cycle_num_i), .finfo_ok_i(finfo_ok_i),
    .sync_found_i(sync_found_i), .sync_lost_i(sync_lost_i), .search_exp_i(search_exp_i),
    .async_i(async_i), .minute_i(minute_i), .lb_sample_i(lb_sample_i), .lb_pin_i(lb_pin_i),
    .eof_i(eof_i), .ovf_i(ovf_i), .read_i(read_i), .status_o(status_o), .attn_o(attn_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    read_i = 1; step(); read_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset word", status_o, 32'h7F00_0000);
    chk("R11 reset attention", {31'd0, attn_o}, 32'd0);
  endtask

  task automatic t_off_ignore();
    sync_found_i = 1; lb_sample_i = 1; lb_pin_i = 1; blk0_end_i = 1;
    frame_num_i = 7'h33; cycle_num_i = 4'h5; finfo_ok_i = 1;
    step();
    sync_found_i = 0; lb_sample_i = 0; lb_pin_i = 0; blk0_end_i = 0; finfo_ok_i = 0;
    chk("R12 strobes ignored while off", status_o, 32'h7F00_0000);
  endtask

  task automatic t_turn_on(input logic pol);
    lb_pol_i = pol; pwr_on_i = 1; step(); pwr_on_i = 0;
    chk("R8 turn-on loads inverse polarity", {30'd0, status_o[14], status_o[6]}, {30'd0, ~pol, 1'b0});
  endtask

  task automatic t_first_expiry();
    search_exp_i = 1; step(); search_exp_i = 0;
    chk("R5 first expiry sets update", {30'd0, status_o[15], status_o[7]}, 32'd1);
    chk("R11 update masked", {31'd0, attn_o}, 32'd0);
    sync_en_i = 1; #1;
    chk("R11 update enabled", {31'd0, attn_o}, 32'd1);
    do_read();
    chk("R10 read clears sync-update", {31'd0, status_o[7]}, 32'd0);
    search_exp_i = 1; step(); search_exp_i = 0;
    chk("R6 later expiry ignored", {31'd0, status_o[7]}, 32'd0);
  endtask

  task automatic t_sync_acquire();
    sync_found_i = 1; step(); sync_found_i = 0;
    chk("R4 R6 sync found", {30'd0, status_o[15], status_o[7]}, 32'd3);
    do_read();
    blk0_end_i = 1; finfo_ok_i = 1; frame_num_i = 7'h55; cycle_num_i = 4'hA;
    step(); blk0_end_i = 0; finfo_ok_i = 0;
    chk("R2 frame info loaded", status_o, 32'h7FD5_CA00);
    blk0_end_i = 1; frame_num_i = 7'h12; cycle_num_i = 4'h3;
    step(); blk0_end_i = 0;
    chk("R2 reload keeps valid", status_o, 32'h7F92_C300);
  endtask

  task automatic t_lowbat();
    lb_sample_i = 1; lb_pin_i = 1; step(); lb_sample_i = 0;
    chk("R7 equal sample no update", {30'd0, status_o[14], status_o[6]}, 32'd2);
    lb_sample_i = 1; lb_pin_i = 0; step(); lb_sample_i = 0;
    chk("R7 differing sample", {30'd0, status_o[14], status_o[6]}, 32'd1);
    chk("R11 battery update attention", {31'd0, attn_o}, 32'd1);
    do_read();
    chk("R10 read clears battery update", {30'd0, status_o[6], attn_o}, 32'd0);
  endtask

  task automatic t_collide();
    minute_en_i = 0;
    minute_i = 1; read_i = 1; step(); minute_i = 0; read_i = 0;
    chk("R10 event with read survives", {31'd0, status_o[4]}, 32'd1);
    chk("R11 minute masked", {31'd0, attn_o}, 32'd0);
    minute_en_i = 1; #1;
    chk("R11 minute enabled", {31'd0, attn_o}, 32'd1);
    do_read();
    chk("R10 read clears minute", {31'd0, status_o[4]}, 32'd0);
    minute_i = 1; step(); minute_i = 0;
    chk("R9 minute tick", {31'd0, status_o[4]}, 32'd1);
    do_read();
  endtask

  task automatic t_eof_ovf();
    eof_i = 1; step(); eof_i = 0;
    chk("R9 end of frame", {30'd0, status_o[2], attn_o}, 32'd3);
    do_read();
    chk("R10 read clears eof", {30'd0, status_o[2], attn_o}, 32'd0);
    ovf_i = 1; step(); ovf_i = 0;
    chk("R9 overflow", {30'd0, status_o[0], attn_o}, 32'd3);
    do_read();
    chk("R10 read clears overflow", status_o[7:0], 32'd0);
  endtask

  task automatic t_sync_lost();
    sync_lost_i = 1; step(); sync_lost_i = 0;
    chk("R3 R6 sync lost", {29'd0, status_o[23], status_o[15], status_o[7]}, 32'd1);
    do_read();
    sync_found_i = 1; step(); sync_found_i = 0;
    do_read();
    blk0_end_i = 1; finfo_ok_i = 1; step(); blk0_end_i = 0; finfo_ok_i = 0;
    chk("R2 valid after reacquire", {31'd0, status_o[23]}, 32'd1);
    async_i = 1; step(); async_i = 0;
    chk("R3 async clears valid", {29'd0, status_o[23], status_o[15], status_o[7]}, 32'd2);
  endtask

  task automatic t_turn_off();
    pwr_off_i = 1; step(); pwr_off_i = 0;
    chk("R4 R6 off drops sync silently", {29'd0, status_o[23], status_o[15], status_o[7]}, 32'd0);
    sync_found_i = 1; step(); sync_found_i = 0;
    chk("R12 sync found ignored while off", {30'd0, status_o[15], status_o[7]}, 32'd0);
  endtask

  task automatic t_restart();
    t_turn_on(1'b0);
    lb_sample_i = 1; lb_pin_i = 0; step(); lb_sample_i = 0;
    chk("R7 first sample vs loaded value", {30'd0, status_o[14], status_o[6]}, 32'd1);
    do_read();
    sync_found_i = 1; step(); sync_found_i = 0;
    chk("R5 first acquisition after restart", {30'd0, status_o[15], status_o[7]}, 32'd3);
    chk("R1 id and unused bits", status_o & 32'hFF00_302A, 32'h7F00_0000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    t_reset();
    t_off_ignore();
    t_turn_on(1'b0);
    t_first_expiry();
    t_sync_acquire();
    t_lowbat();
    t_collide();
    t_eof_ovf();
    t_sync_lost();
    t_turn_off();
    t_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule